// File: doc/BRIEF.md
# Windowed Register File

This block is the operand store of a small load/store processor. Software names registers with a 5-bit architectural index. A window pointer picks which 32-entry slice of a larger physical array those indices reach. The running subroutine can therefore see only the registers of its own window. Two read ports are combinational. One write port updates the array on the clock edge. This serves the usual two-source, one-destination instruction in a single cycle.

A call strobe advances the window pointer by one. On the same edge, it stores the caller's program counter into a chosen register of the window that becomes active. The caller's window is not touched. A return strobe moves the pointer back by one. A call at the last window, or a return at window 0, leaves the pointer where it is and raises a status flag instead. Saving windows to memory is handled elsewhere.

Top module: `windowed_regfile`

## Requirements
- R1: A synchronous active-high reset sets the window pointer to 0 and clears both the overflow and underflow flags on the next clock edge.
- R2: Each of the two read ports combinationally returns the physical register whose address is the window pointer (upper bits) concatenated with the port's 5-bit index (lower bits). The two ports are independent.
- R3: With the write enable high, the write data is stored at the edge in register {window pointer, write index}. A read of that register in the same cycle returns the old value.
- R4: A call below the last window increments the pointer at the edge. The call's return address is stored into register {pointer+1, call destination index}.
- R5: A return above window 0 decrements the pointer at the edge. A normal write in that cycle lands in the window that was active before the return.
- R6: A call while the pointer is at the last window (3 by default) leaves the pointer unchanged, sets the overflow flag and stores no return address. A normal write in that cycle is still performed.
- R7: A return while the pointer is 0 leaves the pointer at 0 and sets the underflow flag. A normal write in that cycle is still performed.
- R8: A successful call or return clears both flags. An overflowing call clears the underflow flag, and an underflowing return clears the overflow flag. With no strobe both flags hold. The two flags are never set together.
- R9: When a successful call and a normal write occur in the same cycle, only the return-address write happens. The normal write is discarded.
- R10: When call and return are strobed together, the return is ignored and the cycle acts as a call.
- R11: The same architectural index in different windows names distinct storage. A write in one window leaves the others unchanged.
- R12: Reset does not alter register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rs_a_idx | input | 5 | Architectural index for read port A |
| rs_a_data | output | 32 | Read port A data |
| rs_b_idx | input | 5 | Architectural index for read port B |
| rs_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 5 | Architectural index of the normal write |
| wr_data | input | 32 | Normal write data |
| call_i | input | 1 | Call strobe |
| call_rd | input | 5 | Callee-window index receiving the return address |
| call_pc | input | 32 | Return address to store on a call |
| ret_i | input | 1 | Return strobe |
| win_ptr | output | 2 | Active window number |
| ovf_flag | output | 1 | Window overflow status |
| unf_flag | output | 1 | Window underflow status |

## Verification
The main translation path is tried with a walk that climbs from window 0 to the last window and back down. Along the way it writes the same index in several windows, so a wrong window field in the address shows up as a value from a neighbouring window. Calls are paired with a same-cycle normal write aimed at a register whose value is later read back. This separates correct call priority from a lost or misplaced deposit. Faulting calls and returns carry a normal write, which shows that a fault stops only the pointer move and the deposit. Directed steps compare a read in the cycle of its write against the read one cycle later, and read registers back after reset.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    // Architectural register index width shared by every port of the file.
    localparam int unsigned WRF_IDX_W = 5;

    // Window move decided for the current cycle.
    typedef enum logic [2:0] {
        WOP_IDLE  = 3'd0,
        WOP_CALL  = 3'd1,
        WOP_RET   = 3'd2,
        WOP_OVF   = 3'd3,
        WOP_UNF   = 3'd4
    } win_op_e;

endpackage

// File: rtl/wrf_addr_map.sv
// Translates an architectural index into a physical array address.
module wrf_addr_map #(
    parameter int unsigned PTR_W = 2,
    parameter int unsigned IDX_W = 5,
    localparam int unsigned AW   = PTR_W + IDX_W
) (
    input  logic [PTR_W-1:0] win,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    phys
);

    always_comb begin
        phys = {win, idx};
    end

endmodule

// File: rtl/wrf_win_ctrl.sv
// Window pointer and status flags.
module wrf_win_ctrl
    import wrf_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    localparam int unsigned PTR_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] next_win,
    output logic             call_ok,
    output logic             ovf_q,
    output logic             unf_q
);

    localparam logic [PTR_W-1:0] LAST_WIN = PTR_W'(NUM_WIN - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             ovf;
        logic             unf;
    } win_state_t;

    win_state_t st_d;
    win_state_t st_q;
    win_op_e    op_d;

    always_comb begin
        op_d = WOP_IDLE;
        if (call_i) begin
            op_d = (st_q.ptr == LAST_WIN) ? WOP_OVF : WOP_CALL;
        end else if (ret_i) begin
            op_d = (st_q.ptr == '0) ? WOP_UNF : WOP_RET;
        end

        st_d = st_q;
        unique case (op_d)
            WOP_CALL: begin
                st_d.ptr = st_q.ptr + 1'b1;
                st_d.ovf = 1'b0;
                st_d.unf = 1'b0;
            end
            WOP_RET: begin
                st_d.ptr = st_q.ptr - 1'b1;
                st_d.ovf = 1'b0;
                st_d.unf = 1'b0;
            end
            WOP_OVF: begin
                st_d.ovf = 1'b1;
                st_d.unf = 1'b0;
            end
            WOP_UNF: begin
                st_d.ovf = 1'b0;
                st_d.unf = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ptr: '0, ovf: 1'b0, unf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_q    = st_q.ptr;
    assign next_win = st_q.ptr + 1'b1;
    assign call_ok  = (op_d == WOP_CALL);
    assign ovf_q    = st_q.ovf;
    assign unf_q    = st_q.unf;

    // R1: reset returns pointer and flags to idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (ptr_q == '0 && !ovf_q && !unf_q));

    // R4: a call below the top advances the pointer
    p_call_adv_r4: assert property (@(posedge clk) disable iff (rst)
        (call_i && ptr_q != LAST_WIN) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R4: the pointer never leaves the configured range
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST_WIN);

    // R5, R10: a return without a call steps the pointer back
    p_ret_back_r5: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && ptr_q != '0) |=> (ptr_q == $past(ptr_q) - 1'b1));

    // R6: call at the top window holds the pointer and flags overflow
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (call_i && ptr_q == LAST_WIN) |=> (ovf_q && $stable(ptr_q)));

    // R7: return at window 0 holds the pointer and flags underflow
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && ptr_q == '0) |=> (unf_q && ptr_q == '0));

    // R8: both flags are never raised together
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_q, unf_q}));

    // R8: without a strobe the flags hold
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!call_i && !ret_i) |=> ($stable(ovf_q) && $stable(unf_q)));

endmodule

// File: rtl/wrf_wr_arb.sv
// Chooses between the call deposit and the normal write for the one write port.
module wrf_wr_arb #(
    parameter int unsigned PTR_W  = 2,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AW    = PTR_W + IDX_W
) (
    input  logic [PTR_W-1:0]  cur_win,
    input  logic [PTR_W-1:0]  new_win,
    input  logic              call_ok,
    input  logic [IDX_W-1:0]  call_rd,
    input  logic [DATA_W-1:0] call_pc,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              phys_we,
    output logic [AW-1:0]     phys_waddr,
    output logic [DATA_W-1:0] phys_wdata
);

    logic [AW-1:0] call_addr;
    logic [AW-1:0] norm_addr;

    wrf_addr_map #(.PTR_W(PTR_W), .IDX_W(IDX_W)) i_map_call (
        .win  (new_win),
        .idx  (call_rd),
        .phys (call_addr)
    );

    wrf_addr_map #(.PTR_W(PTR_W), .IDX_W(IDX_W)) i_map_norm (
        .win  (cur_win),
        .idx  (wr_idx),
        .phys (norm_addr)
    );

    always_comb begin
        if (call_ok) begin
            phys_we    = 1'b1;
            phys_waddr = call_addr;
            phys_wdata = call_pc;
        end else begin
            phys_we    = wr_en;
            phys_waddr = norm_addr;
            phys_wdata = wr_data;
        end
    end

endmodule

// File: rtl/wrf_storage.sv
// Physical register array: one edge-triggered write port, NUM_RD combinational reads.
module wrf_storage #(
    parameter int unsigned AW     = 7,
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_RD = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     rd_addr [NUM_RD],
    output logic [DATA_W-1:0] rd_data [NUM_RD]
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_data[g] = mem_q[rd_addr[g]];
    end

endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
    import wrf_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = WRF_IDX_W,
    localparam int unsigned PTR_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int unsigned AW     = PTR_W + IDX_W,
    localparam int unsigned DEPTH  = NUM_WIN << IDX_W,
    localparam int unsigned NUM_RD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rs_a_idx,
    output logic [DATA_W-1:0] rs_a_data,
    input  logic [IDX_W-1:0]  rs_b_idx,
    output logic [DATA_W-1:0] rs_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_i,
    input  logic [IDX_W-1:0]  call_rd,
    input  logic [DATA_W-1:0] call_pc,
    input  logic              ret_i,
    output logic [PTR_W-1:0]  win_ptr,
    output logic              ovf_flag,
    output logic              unf_flag
);

    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  next_win;
    logic              call_ok;
    logic              phys_we;
    logic [AW-1:0]     phys_waddr;
    logic [DATA_W-1:0] phys_wdata;
    logic [IDX_W-1:0]  rd_idx  [NUM_RD];
    logic [AW-1:0]     rd_addr [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];

    wrf_win_ctrl #(.NUM_WIN(NUM_WIN)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .ptr_q    (ptr_q),
        .next_win (next_win),
        .call_ok  (call_ok),
        .ovf_q    (ovf_flag),
        .unf_q    (unf_flag)
    );

    wrf_wr_arb #(.PTR_W(PTR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_arb (
        .cur_win    (ptr_q),
        .new_win    (next_win),
        .call_ok    (call_ok),
        .call_rd    (call_rd),
        .call_pc    (call_pc),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .phys_we    (phys_we),
        .phys_waddr (phys_waddr),
        .phys_wdata (phys_wdata)
    );

    assign rd_idx[0] = rs_a_idx;
    assign rd_idx[1] = rs_b_idx;

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rmap
        wrf_addr_map #(.PTR_W(PTR_W), .IDX_W(IDX_W)) i_map_rd (
            .win  (ptr_q),
            .idx  (rd_idx[g]),
            .phys (rd_addr[g])
        );
    end

    wrf_storage #(.AW(AW), .DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) i_store (
        .clk     (clk),
        .we      (phys_we),
        .waddr   (phys_waddr),
        .wdata   (phys_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign rs_a_data = rd_data[0];
    assign rs_b_data = rd_data[1];
    assign win_ptr   = ptr_q;

    // R4: the deposit's window field is the window that becomes active
    p_deposit_win_r4: assert property (@(posedge clk) disable iff (rst)
        call_ok |=> (win_ptr == $past(phys_waddr[AW-1:IDX_W])));

    // R9: an accepted call owns the write port over a normal write
    p_call_wins_r9: assert property (@(posedge clk) disable iff (rst)
        call_ok |-> (phys_we && phys_wdata == call_pc));

    // R6: an overflowing call still lets a normal write through
    p_ovf_write_r6: assert property (@(posedge clk) disable iff (rst)
        (call_i && !call_ok && wr_en) |-> (phys_we && phys_waddr[AW-1:IDX_W] == win_ptr));

endmodule

// File: tb/test_windowed_regfile.sv
`timescale 1ns/1ps
module test_windowed_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rs_a_idx = '0;
    logic [31:0] rs_a_data;
    logic [4:0]  rs_b_idx = '0;
    logic [31:0] rs_b_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        call_i = 1'b0;
    logic [4:0]  call_rd = '0;
    logic [31:0] call_pc = '0;
    logic        ret_i = 1'b0;
    logic [1:0]  win_ptr;
    logic        ovf_flag;
    logic        unf_flag;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    windowed_regfile i_windowed_regfile (
        .clk(clk), .rst(rst),
        .rs_a_idx(rs_a_idx), .rs_a_data(rs_a_data),
        .rs_b_idx(rs_b_idx), .rs_b_data(rs_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_i(call_i), .call_rd(call_rd), .call_pc(call_pc),
        .ret_i(ret_i), .win_ptr(win_ptr),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    typedef struct packed {
        logic        call;
        logic        ret;
        logic        we;
        logic [4:0]  widx;
        logic [31:0] wdata;
        logic [4:0]  crd;
        logic [31:0] cpc;
        logic [4:0]  ridx;
        logic [1:0]  eptr;
        logic        eovf;
        logic        eunf;
        logic [31:0] erd;
    } vec_t;

    localparam int NV = 16;

    localparam vec_t VECS [NV] = '{
        // 0 R3: write window 0
        '{1'b0,1'b0,1'b1,5'd3,32'hA000_0003,5'd0,32'h0,5'd3,2'd0,1'b0,1'b0,32'hA000_0003},
        // 1 R2: second write, read the earlier one
        '{1'b0,1'b0,1'b1,5'd7,32'hA000_0007,5'd0,32'h0,5'd3,2'd0,1'b0,1'b0,32'hA000_0003},
        // 2 R4: call deposits into window 1
        '{1'b1,1'b0,1'b0,5'd0,32'h0,5'd15,32'h0000_1000,5'd15,2'd1,1'b0,1'b0,32'h0000_1000},
        // 3 R11: same index, other window
        '{1'b0,1'b0,1'b1,5'd3,32'hB000_0003,5'd0,32'h0,5'd3,2'd1,1'b0,1'b0,32'hB000_0003},
        // 4 R9: call plus normal write, call wins
        '{1'b1,1'b0,1'b1,5'd3,32'hDEAD_0003,5'd15,32'h0000_2000,5'd15,2'd2,1'b0,1'b0,32'h0000_2000},
        // 5 R4: climb to last window
        '{1'b1,1'b0,1'b0,5'd0,32'h0,5'd1,32'h0000_3000,5'd1,2'd3,1'b0,1'b0,32'h0000_3000},
        // 6 R6: overflow, normal write still done
        '{1'b1,1'b0,1'b1,5'd2,32'hE000_0002,5'd1,32'h0000_4000,5'd2,2'd3,1'b1,1'b0,32'hE000_0002},
        // 7 R6 R8: no deposit on overflow, flag held
        '{1'b0,1'b0,1'b0,5'd0,32'h0,5'd0,32'h0,5'd1,2'd3,1'b1,1'b0,32'h0000_3000},
        // 8 R5 R8: return with write to old window, flag cleared
        '{1'b0,1'b1,1'b1,5'd5,32'hF000_0005,5'd0,32'h0,5'd15,2'd2,1'b0,1'b0,32'h0000_2000},
        // 9 R10 R5: call and return together act as call
        '{1'b1,1'b1,1'b0,5'd0,32'h0,5'd6,32'h0000_5000,5'd5,2'd3,1'b0,1'b0,32'hF000_0005},
        // 10 R5
        '{1'b0,1'b1,1'b0,5'd0,32'h0,5'd0,32'h0,5'd15,2'd2,1'b0,1'b0,32'h0000_2000},
        // 11 R9 R11: discarded write left window 1 intact
        '{1'b0,1'b1,1'b0,5'd0,32'h0,5'd0,32'h0,5'd3,2'd1,1'b0,1'b0,32'hB000_0003},
        // 12 R5: back to window 0
        '{1'b0,1'b1,1'b0,5'd0,32'h0,5'd0,32'h0,5'd7,2'd0,1'b0,1'b0,32'hA000_0007},
        // 13 R7: underflow, normal write still done
        '{1'b0,1'b1,1'b1,5'd8,32'h1111_0008,5'd0,32'h0,5'd8,2'd0,1'b0,1'b1,32'h1111_0008},
        // 14 R8: underflow flag held
        '{1'b0,1'b0,1'b0,5'd0,32'h0,5'd0,32'h0,5'd3,2'd0,1'b0,1'b1,32'hA000_0003},
        // 15 R8 R4: successful call clears underflow
        '{1'b1,1'b0,1'b0,5'd0,32'h0,5'd9,32'h0000_6000,5'd9,2'd1,1'b0,1'b0,32'h0000_6000}
    };

    localparam string VREQ [NV] = '{
        "R3", "R2", "R4", "R11", "R9", "R4", "R6", "R6", "R5",
        "R10", "R5", "R9", "R5", "R7", "R8", "R8"
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; call_i = 1'b0; ret_i = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R1: state after reset
        chk("R1", "ptr after reset", 32'(win_ptr), 32'd0);
        chk("R1", "ovf after reset", 32'(ovf_flag), 32'd0);
        chk("R1", "unf after reset", 32'(unf_flag), 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            call_i   = VECS[v].call;
            ret_i    = VECS[v].ret;
            wr_en    = VECS[v].we;
            wr_idx   = VECS[v].widx;
            wr_data  = VECS[v].wdata;
            call_rd  = VECS[v].crd;
            call_pc  = VECS[v].cpc;
            rs_a_idx = VECS[v].ridx;
            tick();
            idle_inputs();
            chk(VREQ[v], $sformatf("vec%0d ptr", v), 32'(win_ptr), 32'(VECS[v].eptr));
            chk(VREQ[v], $sformatf("vec%0d ovf", v), 32'(ovf_flag), 32'(VECS[v].eovf));
            chk(VREQ[v], $sformatf("vec%0d unf", v), 32'(unf_flag), 32'(VECS[v].eunf));
            chk(VREQ[v], $sformatf("vec%0d read", v), rs_a_data, VECS[v].erd);
        end

        // R3: same-cycle read sees old value, next cycle sees new (window 1)
        wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'h1234_5678; rs_b_idx = 5'd3;
        #1;
        chk("R3", "read during write", rs_b_data, 32'hB000_0003);
        tick();
        wr_en = 1'b0;
        chk("R3", "read after write", rs_b_data, 32'h1234_5678);

        // R2: both ports at once on different indices
        rs_a_idx = 5'd9; rs_b_idx = 5'd3;
        #1;
        chk("R2", "port A", rs_a_data, 32'h0000_6000);
        chk("R2", "port B", rs_b_data, 32'h1234_5678);

        // R1 R12: reset from window 1 keeps contents
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1", "ptr after mid-run reset", 32'(win_ptr), 32'd0);
        rs_a_idx = 5'd3; rs_b_idx = 5'd8;
        #1;
        chk("R12", "window 0 idx3 kept", rs_a_data, 32'hA000_0003);
        chk("R12", "window 0 idx8 kept", rs_b_data, 32'h1111_0008);

        // R1: reset clears a raised underflow flag
        ret_i = 1'b1;
        tick();
        ret_i = 1'b0;
        chk("R7", "underflow raised", 32'(unf_flag), 32'd1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1", "underflow cleared by reset", 32'(unf_flag), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule